// File: doc/BRIEF.md
# Cyclic Register Access Bridge

This block sits on the slave side of a cyclic host exchange. Every cycle in which the host presents a request, the block receives one control byte and one 16-bit data word. Bit 7 of the control byte picks what the pair means. With bit 7 clear, the pair is process data. The block forwards the lower control bits and the data word to the application, and answers with the application's live status bits and data word. With bit 7 set, the pair is a register access. The block reads or writes one of 64 internal 16-bit registers and answers with an acknowledgement that echoes the request.

The reply is registered. It appears in the cycle after the request and holds until the next request. The host can therefore match each reply to its request by comparing the echoed bits. In process mode, control bit 0 requests a base-frequency choice. That choice becomes active only when the same request also sets control bit 3, which acts as the reset for the selection. Status bit 0 always shows the active choice, so the host can see when the change has taken effect.

Top module: `cyclic_reg_bridge`

## Requirements
- R1: While rst_n is low, and after reset until the first request, rsp_status, rsp_data, app_ctrl and app_data_out read 0, app_strobe is 0, every register holds 0 and the active frequency selection is 0.
- R2: The cycle after a request, rsp_status bit 7 equals bit 7 of that request's control byte (1 = register access, 0 = process data).
- R3: A register-mode request with control bit 6 = 1 writes req_data to the register addressed by control bits 5..0, exactly once. The next cycle, rsp_status equals the control byte and rsp_data equals the written word.
- R4: A register-mode request with control bit 6 = 0 leaves the register unchanged. The next cycle, rsp_status equals the control byte and rsp_data holds the register's value.
- R5: A process-mode request raises app_strobe for exactly the next cycle and loads app_ctrl with control bits 6..0 and app_data_out with req_data. Register-mode requests do not strobe and leave app_ctrl and app_data_out unchanged. Process requests never modify the register file.
- R6: The cycle after a process-mode request, rsp_status is {0, app_status[5:0], active frequency selection}. rsp_data equals the app_data_in value sampled with the request.
- R7: The active frequency selection takes the value of control bit 0 only on a process-mode request that also has control bit 3 set. Otherwise it keeps its value. The reply to a loading request already shows the new value.
- R8: In a cycle with req_valid low, nothing is written. rsp_status, rsp_data, app_ctrl and app_data_out hold, and app_strobe is 0 in the next cycle.
- R9: All 64 addresses are distinct storage. Address 0 and address 63 are both reachable, and an address never written reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_ctrl | input | 8 | Control byte: mode, direction/process bits, address |
| req_data | input | 16 | Host data word (register data or process data) |
| app_status | input | 6 | Live application status bits returned in process mode |
| app_data_in | input | 16 | Application data word returned in process mode |
| rsp_status | output | 8 | Status byte replied to the host |
| rsp_data | output | 16 | Data word replied to the host |
| app_ctrl | output | 7 | Last process-mode control bits forwarded to the application |
| app_data_out | output | 16 | Last process-mode data word forwarded to the application |
| app_strobe | output | 1 | One-cycle pulse marking a new process-mode transfer |

## Verification
On every cycle the assertions check the following: the mode echo in the reply, the address and direction echo of register replies, the returned write data, the one-cycle strobe, the live status bits in process replies, the hold of the reply on idle cycles, and the stability of the frequency selection outside loading requests. What a read returns depends on earlier writes, so only the bench's scenarios can show it. This covers the stored values at both ends of the address range, the zero of an unwritten register, that process traffic and requests without valid leave the registers alone, and that a mid-run reset clears the stored contents.

// File: rtl/crb_pkg.sv
package crb_pkg;
  localparam int CTRL_W    = 8;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = CTRL_W - 2;
  localparam int REG_N     = 1 << ADDR_W;
  localparam int APP_ST_W  = CTRL_W - 2;
  localparam int MODE_BIT  = CTRL_W - 1;
  localparam int DIR_BIT   = CTRL_W - 2;
  localparam int FREQ_BIT  = 0;
  localparam int LOAD_BIT  = 3;

  typedef struct packed {
    logic              reg_mode;
    logic              wr;
    logic [ADDR_W-1:0] addr;
  } ctrl_t;

  function automatic ctrl_t split_ctrl(input logic [CTRL_W-1:0] c);
    ctrl_t f;
    f.reg_mode = c[MODE_BIT];
    f.wr       = c[DIR_BIT];
    f.addr     = c[ADDR_W-1:0];
    return f;
  endfunction

  function automatic logic [CTRL_W-1:0] reg_reply(input ctrl_t f);
    return {1'b1, f.wr, f.addr};
  endfunction

  function automatic logic [CTRL_W-1:0] proc_reply(input logic [APP_ST_W-1:0] st,
                                                   input logic fsel);
    return {1'b0, st, fsel};
  endfunction

  function automatic logic next_fsel(input logic fire, input logic [CTRL_W-1:0] c,
                                     input logic cur);
    return (fire && c[LOAD_BIT]) ? c[FREQ_BIT] : cur;
  endfunction
endpackage

// File: rtl/crb_decode.sv
module crb_decode
  import crb_pkg::*;
(
  input  logic              valid,
  input  logic [CTRL_W-1:0] ctrl,
  output ctrl_t             fields,
  output logic              wr_fire,
  output logic              rd_fire,
  output logic              proc_fire
);
  always_comb begin
    fields    = split_ctrl(ctrl);
    wr_fire   = valid &&  fields.reg_mode &&  fields.wr;
    rd_fire   = valid &&  fields.reg_mode && !fields.wr;
    proc_fire = valid && !fields.reg_mode;
  end
endmodule

// File: rtl/crb_regfile.sv
module crb_regfile #(
  parameter int W     = 16,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] word_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        word_q[g] <= '0;
      else if (we && (waddr == AW'(g)))
        word_q[g] <= wdata;
    end
  end

  assign rdata = word_q[raddr];
endmodule

// File: rtl/crb_proc_path.sv
module crb_proc_path
  import crb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [DATA_W-1:0] data,
  output logic [CTRL_W-2:0] app_ctrl,
  output logic [DATA_W-1:0] app_data_out,
  output logic              app_strobe,
  output logic              fsel_q,
  output logic              fsel_d
);
  assign fsel_d = next_fsel(fire, ctrl, fsel_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      app_ctrl     <= '0;
      app_data_out <= '0;
      app_strobe   <= 1'b0;
      fsel_q       <= 1'b0;
    end else begin
      app_strobe <= fire;
      fsel_q     <= fsel_d;
      if (fire) begin
        app_ctrl     <= ctrl[CTRL_W-2:0];
        app_data_out <= data;
      end
    end
  end
endmodule

// File: rtl/cyclic_reg_bridge.sv
module cyclic_reg_bridge
  import crb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [CTRL_W-1:0]   req_ctrl,
  input  logic [DATA_W-1:0]   req_data,
  input  logic [APP_ST_W-1:0] app_status,
  input  logic [DATA_W-1:0]   app_data_in,
  output logic [CTRL_W-1:0]   rsp_status,
  output logic [DATA_W-1:0]   rsp_data,
  output logic [CTRL_W-2:0]   app_ctrl,
  output logic [DATA_W-1:0]   app_data_out,
  output logic                app_strobe
);
  ctrl_t             req_f;
  logic              wr_fire, rd_fire, proc_fire;
  logic [DATA_W-1:0] reg_rdata;
  logic              freq_active, freq_next;

  crb_decode u_dec (
    .valid     (req_valid),
    .ctrl      (req_ctrl),
    .fields    (req_f),
    .wr_fire   (wr_fire),
    .rd_fire   (rd_fire),
    .proc_fire (proc_fire)
  );

  crb_regfile #(.W(DATA_W), .DEPTH(REG_N)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_fire),
    .waddr (req_f.addr),
    .wdata (req_data),
    .raddr (req_f.addr),
    .rdata (reg_rdata)
  );

  crb_proc_path u_proc (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire         (proc_fire),
    .ctrl         (req_ctrl),
    .data         (req_data),
    .app_ctrl     (app_ctrl),
    .app_data_out (app_data_out),
    .app_strobe   (app_strobe),
    .fsel_q       (freq_active),
    .fsel_d       (freq_next)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_status <= '0;
      rsp_data   <= '0;
    end else if (wr_fire) begin
      rsp_status <= reg_reply(req_f);
      rsp_data   <= req_data;
    end else if (rd_fire) begin
      rsp_status <= reg_reply(req_f);
      rsp_data   <= reg_rdata;
    end else if (proc_fire) begin
      rsp_status <= proc_reply(app_status, freq_next);
      rsp_data   <= app_data_in;
    end
  end
endmodule

// File: rtl/crb_checker.sv
module crb_checker
  import crb_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                req_valid,
  input logic [CTRL_W-1:0]   req_ctrl,
  input logic [DATA_W-1:0]   req_data,
  input logic [APP_ST_W-1:0] app_status,
  input logic [CTRL_W-1:0]   rsp_status,
  input logic [DATA_W-1:0]   rsp_data,
  input logic                app_strobe,
  input logic                freq_active
);
  p_mode_echo_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_status[MODE_BIT] == $past(req_ctrl[MODE_BIT]));

  p_reg_echo_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ctrl[MODE_BIT]) |=> rsp_status == $past(req_ctrl));

  p_write_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ctrl[MODE_BIT] && req_ctrl[DIR_BIT]) |=> rsp_data == $past(req_data));

  p_strobe_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ctrl[MODE_BIT]) |=> app_strobe);

  p_strobe_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_ctrl[MODE_BIT]) |=> !app_strobe);

  p_live_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ctrl[MODE_BIT]) |=> rsp_status[CTRL_W-2:1] == $past(app_status));

  p_fsel_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ctrl[MODE_BIT]) |=> rsp_status[0] == freq_active);

  p_fsel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_ctrl[MODE_BIT] && req_ctrl[LOAD_BIT]) |=> $stable(freq_active));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(rsp_status) && $stable(rsp_data)));
endmodule

bind cyclic_reg_bridge crb_checker u_chk (.*);

// File: tb/cyclic_reg_bridge_test.sv
`timescale 1ns/1ps
module cyclic_reg_bridge_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [7:0]  req_ctrl = '0;
  logic [15:0] req_data = '0;
  logic [5:0]  app_status = '0;
  logic [15:0] app_data_in = '0;
  logic [7:0]  rsp_status;
  logic [15:0] rsp_data;
  logic [6:0]  app_ctrl;
  logic [15:0] app_data_out;
  logic        app_strobe;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  cyclic_reg_bridge uut (.*);

  typedef struct packed {
    logic [7:0]  ctrl;
    logic [15:0] data;
    logic [5:0]  st;
    logic [15:0] din;
    logic [7:0]  exp_st;
    logic [15:0] exp_data;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{8'hC5, 16'h1234, 6'h00, 16'h0000, 8'hC5, 16'h1234}, // R3 write a5
    '{8'hFF, 16'hBEEF, 6'h00, 16'h0000, 8'hFF, 16'hBEEF}, // R3 R9 write a63
    '{8'hC0, 16'h0F0F, 6'h00, 16'h0000, 8'hC0, 16'h0F0F}, // R3 R9 write a0
    '{8'h85, 16'hFFFF, 6'h00, 16'h0000, 8'h85, 16'h1234}, // R4 read a5
    '{8'hBF, 16'h0000, 6'h00, 16'h0000, 8'hBF, 16'hBEEF}, // R4 R9 read a63
    '{8'h80, 16'h0000, 6'h00, 16'h0000, 8'h80, 16'h0F0F}, // R4 R9 read a0
    '{8'h86, 16'h0000, 6'h00, 16'h0000, 8'h86, 16'h0000}, // R9 unwritten
    '{8'h01, 16'h1111, 6'h2A, 16'hA5A5, 8'h54, 16'hA5A5}, // R6 R7 no load
    '{8'h09, 16'h2222, 6'h15, 16'h5A5A, 8'h2B, 16'h5A5A}, // R7 load 1
    '{8'h00, 16'h3333, 6'h00, 16'h0000, 8'h01, 16'h0000}, // R7 held
    '{8'h08, 16'h4444, 6'h3F, 16'h7777, 8'h7E, 16'h7777}, // R7 load 0
    '{8'h85, 16'h0000, 6'h00, 16'h0000, 8'h85, 16'h1234}  // R5 regs untouched
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] c, input logic [15:0] d,
                      input logic [5:0] s, input logic [15:0] di, input logic v);
    @(negedge clk);
    req_valid = v; req_ctrl = c; req_data = d; app_status = s; app_data_in = di;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [6:0]  keep_ctrl;
    logic [15:0] keep_dout;
    repeat (3) @(negedge clk);
    chk("R1 status", 32'(rsp_status), 32'h0);
    chk("R1 data", 32'(rsp_data), 32'h0);
    chk("R1 strobe", 32'(app_strobe), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 app_ctrl", 32'(app_ctrl), 32'h0);

    for (int i = 0; i < NV; i++) begin
      send(VEC[i].ctrl, VEC[i].data, VEC[i].st, VEC[i].din, 1'b1);
      chk($sformatf("R2 R3 R4 R6 status vec%0d", i), 32'(rsp_status), 32'(VEC[i].exp_st));
      chk($sformatf("R3 R4 R6 data vec%0d", i), 32'(rsp_data), 32'(VEC[i].exp_data));
      chk($sformatf("R5 strobe vec%0d", i), 32'(app_strobe), 32'(!VEC[i].ctrl[7]));
      if (!VEC[i].ctrl[7]) begin
        chk($sformatf("R5 app_ctrl vec%0d", i), 32'(app_ctrl), 32'(VEC[i].ctrl[6:0]));
        chk($sformatf("R5 app_data vec%0d", i), 32'(app_data_out), 32'(VEC[i].data));
      end
    end

    // R5: register traffic leaves forwarded process outputs alone
    keep_ctrl = app_ctrl; keep_dout = app_data_out;
    send(8'hC9, 16'hCAFE, 6'h00, 16'h0000, 1'b1);
    chk("R5 app_ctrl held", 32'(app_ctrl), 32'(keep_ctrl));
    chk("R5 app_data held", 32'(app_data_out), 32'(keep_dout));

    // R8: idle request with write pattern does nothing
    send(8'hC5, 16'hDEAD, 6'h11, 16'h9999, 1'b0);
    chk("R8 status held", 32'(rsp_status), 32'hC9);
    chk("R8 data held", 32'(rsp_data), 32'hCAFE);
    chk("R8 strobe low", 32'(app_strobe), 32'h0);
    send(8'h85, 16'h0000, 6'h00, 16'h0000, 1'b1);
    chk("R8 no write a5", 32'(rsp_data), 32'h1234);
    send(8'h89, 16'h0000, 6'h00, 16'h0000, 1'b1);
    chk("R3 written a9", 32'(rsp_data), 32'hCAFE);

    // R7: select with no load keeps active choice 0
    send(8'h01, 16'h0000, 6'h00, 16'h0000, 1'b1);
    chk("R7 not loaded", 32'(rsp_status), 32'h00);

    // R1: mid-run reset clears storage and selection
    send(8'h09, 16'h0000, 6'h00, 16'h0000, 1'b1);
    chk("R7 loaded before reset", 32'(rsp_status), 32'h01);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset status", 32'(rsp_status), 32'h0);
    chk("R1 reset app_data", 32'(app_data_out), 32'h0);
    rst_n = 1'b1;
    send(8'hBF, 16'h0000, 6'h00, 16'h0000, 1'b1);
    chk("R1 a63 cleared", 32'(rsp_data), 32'h0);
    send(8'h00, 16'h0000, 6'h00, 16'h0000, 1'b1);
    chk("R1 selection cleared", 32'(rsp_status), 32'h00);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule